// File: doc/BRIEF.md
# Gated Power-of-Two Clock Post-Divider

This block sits after a synthesizer's oscillator and turns one fast source clock into two slower output clocks. Output A divides the source by a power of two, from 2 to 64, chosen by a 3-bit code whose bit order is reversed. Output B runs either at the rate of A or at half of it. One master counter drives both outputs, so their rising edges stay in step.

Each output has its own active-low stop input. The block resynchronizes that input and applies it only at a boundary of that output's period. A clock therefore stops low and restarts with full-width pulses. A bypass input routes a slow reference clock into the divider in place of the oscillator. An asynchronous master reset clears both outputs at once.

Top module: `clk_postdiv`

## Requirements
- R1: The divide code sets the period of A in source cycles: 000 gives 2, 100 gives 4, 010 gives 8, 110 gives 16, 001 gives 32 and 101 gives 64. In every case A is high for exactly half the period.
- R2: The codes 011 and 111 select division by 64.
- R3: With `b_half` low, B has the same period and waveform as A.
- R4: With `b_half` high, B has twice the period of A and a 50 % duty cycle. Every rising edge of B falls in the same source cycle as a rising edge of A.
- R5: A change of divide code or `b_half` takes effect only at the end of the counter frame, which is two A periods long. Every pulse has either the old shape or the new shape, never a mix of the two.
- R6: A low stop input holds its output low. Stopping and restarting happen only while the output is low. Every high pulse keeps its full width, and every low gap is half a period plus a whole number of periods.
- R7: The two stop inputs are independent. Stopping one output leaves the other output's edges unchanged.
- R8: With B at half rate, rising edges of A and B still coincide after any number of stop and restart sequences on either output.
- R9: While `rst_n` is low, both outputs are low. Asserting `rst_n` clears them with no source clock edge.
- R10: With `bypass` high, `ref_clk` replaces `vco_clk` as the source, and every period from R1 to R4 is counted in `ref_clk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast oscillator clock, the normal source |
| ref_clk | input | 1 | Reference clock, used as the source when bypassed |
| bypass | input | 1 | High selects `ref_clk` as the divider source |
| rst_n | input | 1 | Asynchronous active-low master reset |
| div_code | input | 3 | Divide code for output A (see R1, R2) |
| b_half | input | 1 | High runs B at half the rate of A |
| stop_a_n | input | 1 | Active-low stop request for A, asynchronous |
| stop_b_n | input | 1 | Active-low stop request for B, asynchronous |
| clk_a | output | 1 | Primary divided clock |
| clk_b | output | 1 | Secondary divided clock |

## Verification
The properties assume that `bypass` changes only while reset is held, because the source selection is a plain multiplexer. They also assume that `div_code` and `b_half` hold steady near the end of a frame, when they are sampled. The stop inputs may change at any instant, and the bench deliberately moves them at offsets that are not aligned to the source clock. The bench changes the divide code once mid-frame, to exercise the deferred switch. It flips `bypass` only with reset asserted.

// File: rtl/postdiv_pkg.sv
package postdiv_pkg;
  localparam int MAX_EXP = 6;
  localparam int CODE_W  = 3;
  localparam int NUM_OUT = 2;

  // The divide code is read with its bits reversed: the reversed value plus
  // one is the power of two. Values past the largest exponent clamp to it.
  function automatic int code_to_exp(input logic [CODE_W-1:0] code, input int max_exp);
    logic [CODE_W-1:0] idx;
    for (int i = 0; i < CODE_W; i++) idx[i] = code[CODE_W-1-i];
    if (int'(idx) >= max_exp) return max_exp;
    return int'(idx) + 1;
  endfunction
endpackage

// File: rtl/postdiv_rst_sync.sv
module postdiv_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/postdiv_count.sv
module postdiv_count
  import postdiv_pkg::*;
#(
  parameter int MAX_EXP_P = MAX_EXP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] ratio_code,
  input  logic              half_sel,
  output logic [1:0]        raw,
  output logic [1:0]        period_end
);
  localparam int CNT_W = MAX_EXP_P + 1;
  localparam int EXP_W = $clog2(CNT_W);

  logic [CNT_W-1:0] cnt_q, cnt_d, mask_a, mask_f;
  logic [EXP_W-1:0] exp_q, exp_d;
  logic             half_q, half_d, frame_end;

  // A uses the low exp bits of the counter; one frame covers two A periods,
  // which is one B period in half-rate mode.
  always_comb begin
    mask_a        = (CNT_W'(1) << exp_q) - CNT_W'(1);
    mask_f        = {mask_a[CNT_W-2:0], 1'b1};
    frame_end     = (cnt_q == mask_f);
    period_end[0] = ((cnt_q & mask_a) == mask_a);
    period_end[1] = half_q ? frame_end : period_end[0];
    raw[0]        = !cnt_q[exp_q - EXP_W'(1)];
    raw[1]        = half_q ? !cnt_q[exp_q] : raw[0];
  end

  always_comb begin
    cnt_d  = cnt_q + CNT_W'(1);
    exp_d  = exp_q;
    half_d = half_q;
    if (frame_end) begin
      cnt_d  = '0;
      exp_d  = EXP_W'(code_to_exp(ratio_code, MAX_EXP_P));
      half_d = half_sel;
    end
  end

  // The reset value is a frame end for any ratio, so the setting is taken
  // on the first cycle after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      exp_q  <= EXP_W'(MAX_EXP_P);
      half_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      exp_q  <= exp_d;
      half_q <= half_d;
    end
  end

  p_exp_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_q >= EXP_W'(1)) && (exp_q <= EXP_W'(MAX_EXP_P)));

  p_cnt_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= mask_f);

  p_switch_at_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(exp_q) || !$stable(half_q)) |-> (cnt_q == '0));
endmodule

// File: rtl/postdiv_gate.sv
module postdiv_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_n,
  input  logic raw,
  input  logic period_end,
  output logic clk_out
);
  logic sync1_q, sync2_q, run_q, run_d, out_d;

  // The run flag moves only on the last source cycle of an output period,
  // when the ungated waveform is low, so no pulse is ever cut short.
  always_comb begin
    run_d = period_end ? sync2_q : run_q;
    out_d = run_q & raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      run_q   <= 1'b0;
      clk_out <= 1'b0;
    end else begin
      sync1_q <= stop_n;
      sync2_q <= sync1_q;
      run_q   <= run_d;
      clk_out <= out_d;
    end
  end

  p_gate_moves_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(run_q) |-> !clk_out);

  p_stopped_stays_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !clk_out);
endmodule

// File: rtl/clk_postdiv.sv
module clk_postdiv
  import postdiv_pkg::*;
#(
  parameter int MAX_EXP_P = MAX_EXP
) (
  input  logic              vco_clk,
  input  logic              ref_clk,
  input  logic              bypass,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] div_code,
  input  logic              b_half,
  input  logic              stop_a_n,
  input  logic              stop_b_n,
  output logic              clk_a,
  output logic              clk_b
);
  logic               src_clk, srst_n;
  logic [NUM_OUT-1:0] raw, period_end, stop_n, outs;

  // Source selection is static: bypass is changed only with reset held.
  assign src_clk = bypass ? ref_clk : vco_clk;
  assign stop_n  = {stop_b_n, stop_a_n};

  postdiv_rst_sync u_rst (
    .clk    (src_clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  postdiv_count #(.MAX_EXP_P(MAX_EXP_P)) u_count (
    .clk        (src_clk),
    .rst_n      (srst_n),
    .ratio_code (div_code),
    .half_sel   (b_half),
    .raw        (raw),
    .period_end (period_end)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    postdiv_gate u_gate (
      .clk        (src_clk),
      .rst_n      (srst_n),
      .stop_n     (stop_n[g]),
      .raw        (raw[g]),
      .period_end (period_end[g]),
      .clk_out    (outs[g])
    );
  end

  assign clk_a = outs[0];
  assign clk_b = outs[1];

  p_rise_aligned_r8: assert property (@(posedge src_clk) disable iff (!srst_n)
    ($rose(clk_b) && clk_a) |-> $rose(clk_a));
endmodule

// File: tb/clk_postdiv_bench.sv
`timescale 1ns/1ps
module clk_postdiv_bench;
  logic       vco_clk, ref_clk, bypass, rst_n, b_half, stop_a_n, stop_b_n;
  logic [2:0] div_code;
  logic       clk_a, clk_b;
  logic       mon_clk;

  int    total, bad;
  int    q[2][$];
  logic  prev[2];
  int    run[2], hi_len[2], edges[2];
  bit    armed[2], seen[2];
  int    exp_hi[2], exp_lo[2], per[2];
  bit    mon_on, shape_on, align_on;
  int    co_rise;
  string cur_req;

  clk_postdiv u_clk_postdiv (
    .vco_clk (vco_clk), .ref_clk (ref_clk), .bypass (bypass), .rst_n (rst_n),
    .div_code (div_code), .b_half (b_half), .stop_a_n (stop_a_n), .stop_b_n (stop_b_n),
    .clk_a (clk_a), .clk_b (clk_b)
  );

  initial begin vco_clk = 1'b0; forever #2 vco_clk = ~vco_clk; end
  initial begin ref_clk = 1'b0; forever #6 ref_clk = ~ref_clk; end
  assign mon_clk = bypass ? ref_clk : vco_clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: measures run lengths in source cycles and pops expected pulses.
  always @(negedge mon_clk) begin : monitor
    logic cur[2];
    cur[0] = clk_a;
    cur[1] = clk_b;
    if (align_on && cur[1] && !prev[1]) begin
      if (cur[0] && prev[0]) chk(1'b0, "R8 B rose inside an A high", 1, 0);
      else if (cur[0]) co_rise++;
    end
    for (int i = 0; i < 2; i++) begin
      if (cur[i] !== prev[i]) begin
        edges[i]++;
        if (prev[i] === 1'b1) begin
          hi_len[i] = run[i];
          if (shape_on && seen[i])
            chk(run[i] == exp_hi[i], $sformatf("R6 high width out%0d", i), run[i], exp_hi[i]);
        end else begin
          if (shape_on && seen[i])
            chk(run[i] >= exp_lo[i] && (run[i] - exp_lo[i]) % per[i] == 0,
                $sformatf("R6 low gap out%0d", i), run[i], exp_lo[i]);
          if (mon_on) begin
            if (armed[i] && q[i].size() > 0) begin
              int e;
              e = q[i].pop_front();
              chk(hi_len[i] * 1000 + run[i] == e, $sformatf("%s out%0d hi*1000+lo", cur_req, i),
                  hi_len[i] * 1000 + run[i], e);
            end
            armed[i] = 1'b1;
          end
          seen[i] = 1'b1;
        end
        run[i] = 1;
      end else begin
        run[i]++;
      end
      prev[i] = cur[i];
    end
  end

  // Driver: applies a setting, lets it settle, then queues expected pulses.
  task automatic measure(input logic [2:0] code, input logic h, input int n, input string req);
    div_code = code;
    b_half   = h;
    repeat (300) @(negedge mon_clk);
    cur_req = req;
    for (int i = 0; i < 2; i++) begin
      armed[i] = 1'b0;
      q[i].delete();
    end
    for (int k = 0; k < 3; k++) begin
      q[0].push_back((n / 2) * 1000 + n / 2);
      q[1].push_back(h ? n * 1000 + n : (n / 2) * 1000 + n / 2);
    end
    mon_on = 1'b1;
    for (int w = 0; w < 3000 && (q[0].size() > 0 || q[1].size() > 0); w++) @(negedge mon_clk);
    mon_on = 1'b0;
    chk(q[0].size() == 0 && q[1].size() == 0, {req, " pulses left"}, q[0].size() + q[1].size(), 0);
  endtask

  task automatic set_shape(input int n, input bit h);
    exp_hi[0] = n / 2; exp_lo[0] = n / 2; per[0] = n;
    exp_hi[1] = h ? n : n / 2; exp_lo[1] = h ? n : n / 2; per[1] = h ? 2 * n : n;
    seen[0] = 1'b0; seen[1] = 1'b0;
  endtask

  // R5: switch from /8 to /4 mid-frame; count completed high widths after it.
  task automatic ratio_switch();
    logic p;
    int   r, n4, n2, other;
    bit   started, late4;
    n4 = 0; n2 = 0; other = 0; started = 1'b0; late4 = 1'b0; r = 0;
    @(negedge vco_clk);
    p = clk_a;
    #1 div_code = 3'b100;
    for (int s = 0; s < 80; s++) begin
      @(negedge vco_clk);
      if (clk_a && !p) begin started = 1'b1; r = 1; end
      else if (clk_a) r++;
      else if (p && started) begin
        if (r == 4) begin n4++; if (n2 > 0) late4 = 1'b1; end
        else if (r == 2) n2++;
        else other++;
      end
      p = clk_a;
    end
    chk(other == 0, "R5 mixed width pulse", other, 0);
    chk(!late4, "R5 old width after new width", int'(late4), 0);
    chk(n4 <= 2, "R5 old pulses past frame end", n4, 2);
    chk(n2 >= 5, "R5 new ratio applied", n2, 5);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge vco_clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    int ea, eb;
    total = 0; bad = 0; mon_on = 1'b0; shape_on = 1'b0; align_on = 1'b0; co_rise = 0;
    prev[0] = 1'b0; prev[1] = 1'b0; run[0] = 0; run[1] = 0; edges[0] = 0; edges[1] = 0;
    bypass = 1'b0; rst_n = 1'b0; div_code = 3'b000; b_half = 1'b0;
    stop_a_n = 1'b1; stop_b_n = 1'b1;
    set_shape(2, 1'b0);
    repeat (5) @(negedge vco_clk);
    chk(clk_a == 1'b0 && clk_b == 1'b0, "R9 reset state", int'({clk_a, clk_b}), 0);
    rst_n = 1'b1;

    measure(3'b000, 1'b0, 2,  "R1 code 000");
    measure(3'b100, 1'b0, 4,  "R1 code 100 R3");
    measure(3'b010, 1'b0, 8,  "R1 code 010");
    measure(3'b110, 1'b0, 16, "R1 code 110");
    measure(3'b001, 1'b0, 32, "R1 code 001");
    measure(3'b101, 1'b0, 64, "R1 code 101 R3");
    measure(3'b011, 1'b0, 64, "R2 code 011");
    measure(3'b111, 1'b0, 64, "R2 code 111");
    measure(3'b000, 1'b1, 2,  "R4 half rate /2");
    measure(3'b110, 1'b1, 16, "R4 half rate /16");

    measure(3'b010, 1'b0, 8, "R5 before switch");
    ratio_switch();

    // R6, R7: independent stops at unaligned instants
    measure(3'b010, 1'b0, 8, "R6 before stop");
    set_shape(8, 1'b0);
    shape_on = 1'b1;
    #7 stop_a_n = 1'b0;
    repeat (40) @(negedge vco_clk);
    #1 ea = edges[0]; eb = edges[1];
    repeat (40) @(negedge vco_clk);
    #1;
    chk(edges[0] == ea && clk_a == 1'b0, "R6 A held low", edges[0] - ea, 0);
    chk(edges[1] - eb == 10, "R7 B unchanged while A stopped", edges[1] - eb, 10);
    #5 stop_a_n = 1'b1;
    repeat (40) @(negedge vco_clk);
    #3 stop_b_n = 1'b0;
    repeat (40) @(negedge vco_clk);
    #1 ea = edges[0]; eb = edges[1];
    repeat (40) @(negedge vco_clk);
    #1;
    chk(edges[1] == eb && clk_b == 1'b0, "R6 B held low", edges[1] - eb, 0);
    chk(edges[0] - ea == 10, "R7 A unchanged while B stopped", edges[0] - ea, 10);
    #1 stop_b_n = 1'b1;
    repeat (40) @(negedge vco_clk);
    #1 eb = edges[1];
    repeat (40) @(negedge vco_clk);
    #1 chk(edges[1] - eb == 10, "R6 B restarted", edges[1] - eb, 10);
    shape_on = 1'b0;

    // R8: repeated staggered stop/restart with B at half rate
    measure(3'b100, 1'b1, 4, "R8 before stops");
    set_shape(4, 1'b1);
    shape_on = 1'b1;
    align_on = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #3 stop_a_n = 1'b0;
      repeat (20 + 3 * k) @(negedge vco_clk);
      #1 stop_b_n = 1'b0;
      repeat (17) @(negedge vco_clk);
      #1 stop_a_n = 1'b1;
      repeat (13 + k) @(negedge vco_clk);
      #2 stop_b_n = 1'b1;
      repeat (30) @(negedge vco_clk);
    end
    #1 co_rise = 0;
    repeat (40) @(negedge vco_clk);
    #1 chk(co_rise == 5, "R8 coincident rises after restarts", co_rise, 5);
    shape_on = 1'b0;
    align_on = 1'b0;

    // R9: asynchronous clear while outputs are high
    @(posedge clk_a);
    #1 rst_n = 1'b0;
    #1 chk(clk_a == 1'b0 && clk_b == 1'b0, "R9 async clear", int'({clk_a, clk_b}), 0);
    repeat (4) @(negedge vco_clk);
    rst_n = 1'b1;
    measure(3'b100, 1'b1, 4, "R9 restart after reset");

    // R10: reference clock as source, switched under reset
    rst_n = 1'b0;
    #1 bypass = 1'b1;
    repeat (4) @(negedge ref_clk);
    rst_n = 1'b1;
    measure(3'b000, 1'b1, 2, "R10 bypass /2 half");
    measure(3'b100, 1'b0, 4, "R10 bypass /4");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule